// File: doc/BRIEF.md
# Program/Erase Status Word Generator

This block is the read-side status logic of a flash-style memory. When the command front end has taken the final write of a program or erase sequence (the fourth write for a word program, the sixth for any erase), it pulses `op_start` together with the operation kind. From that cycle the block runs an internal operation timer whose length depends on the kind. While the timer runs, every read returns a status word instead of array contents. Bit 7 is a polling bit whose value depends on the kind of operation. Bit 6 is a toggle bit that flips once per read access.

When the timer expires, bit 7 shows its final value at once. The rest of the word stays masked for a short settle window. After that, reads pass the external array word through unchanged. While no operation is running, an identification mode can be selected; in that mode address bit 0 chooses between the manufacturer word and the device word. Command decoding and the storage array live outside this block.

Top module: `flash_status_gen`

## Requirements
- R1: After reset `rd_word` is 0x0000, no operation is running, and the toggle bit state is 0. The first read of the first operation therefore shows bit 6 = 1.
- R2: A cycle sampled with `rd_en` low yields `rd_word` = 0x0000 one clock later.
- R3: While a word program is running (`op_kind` = 2'b00), a read returns bit 7 as the inverse of `prog_bit_in`, where `prog_bit_in` is latched at the start pulse.
- R4: While a sector/block erase (`op_kind` = 2'b01) or a chip erase (2'b10; 2'b11 is treated as chip erase) is running, a read returns bit 7 = 0.
- R5: While an operation is running, bit 6 inverts once at the first cycle of each new read access (rising `rd_en`). A read held high across several cycles shows the same bit 6 throughout.
- R6: Status lasts exactly PROG_CYC, SECT_CYC or CHIP_CYC clock edges after the edge that accepts `op_start`, selected by kind. Then comes the settle window, then normal reads.
- R7: For SETTLE_CYC edges after the timer ends, a read shows bit 7 in its final state (the latched program bit, or 1 for any erase). Bit 6 is frozen.
- R8: During the running and settle phases, every bit other than 7 and 6 reads 0.
- R9: With no operation and identification mode off, a read returns `array_word` unchanged, including the erased value 0xFFFF.
- R10: With no operation and `id_mode` high, a read returns 0x00BF when `rd_a0` = 0 and 0x272F when `rd_a0` = 1. A running operation takes precedence over `id_mode`.
- R11: An `op_start` pulse during the running or settle phase is ignored. It neither restarts the timer nor changes the latched kind or program bit.
- R12: Bit 6 keeps its last value after an operation ends, and it does not change while no operation is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | One-cycle pulse: the operation sequence is complete |
| op_kind | input | 2 | 00 word program, 01 sector/block erase, 10/11 chip erase |
| prog_bit_in | input | 1 | Bit 7 of the word being programmed |
| array_word | input | DW | Array contents at the read address |
| rd_en | input | 1 | Read strobe, one access per high period |
| rd_a0 | input | 1 | Read address bit 0 (identification word select) |
| id_mode | input | 1 | Identification read mode selected |
| rd_word | output | DW | Registered read word |

## Verification
Each read result is registered, so it appears one clock after the edge that samples `rd_en`, the address bit and the mode. An operation accepted at edge 0 is reported as running at edges 1 through N, as settling for the next SETTLE_CYC edges, and as done after that. The bench drives all inputs on the falling edge and compares on the next falling edge. It checks against a bench model that advances its own phase counter and toggle state once per edge, so every check lands exactly one register stage after its stimulus.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

   typedef enum logic [1:0] {
      OPK_PROG     = 2'b00,
      OPK_SECT     = 2'b01,
      OPK_CHIP     = 2'b10,
      OPK_CHIP_ALT = 2'b11
   } op_kind_e;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'b00,
      PH_BUSY   = 2'b01,
      PH_SETTLE = 2'b10
   } phase_e;

   function automatic logic kind_is_erase(input op_kind_e k);
      return (k != OPK_PROG);
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fsg_op_timer.sv
module fsg_op_timer
   import flash_status_pkg::*;
#(
   parameter int PROG_CYC   = 8,
   parameter int SECT_CYC   = 64,
   parameter int CHIP_CYC   = 256,
   parameter int SETTLE_CYC = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  op_kind_e kind,
   output logic     accept,
   output phase_e   phase
);

   localparam int LONGEST = max2(max2(PROG_CYC, SECT_CYC), max2(CHIP_CYC, SETTLE_CYC));
   localparam int CW      = (LONGEST < 2) ? 1 : $clog2(LONGEST);

   initial begin
      assert (PROG_CYC >= 1) else $error("PROG_CYC must be at least 1");
      assert (SECT_CYC >= 1) else $error("SECT_CYC must be at least 1");
      assert (CHIP_CYC >= 1) else $error("CHIP_CYC must be at least 1");
      assert (SETTLE_CYC >= 0) else $error("SETTLE_CYC must not be negative");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] load_val;
   phase_e        after_busy_ph;
   logic [CW-1:0] after_busy_cnt;

   generate
      if (SETTLE_CYC > 0) begin : g_settle
         assign after_busy_ph  = PH_SETTLE;
         assign after_busy_cnt = CW'(SETTLE_CYC - 1);
      end else begin : g_nosettle
         assign after_busy_ph  = PH_IDLE;
         assign after_busy_cnt = '0;
      end
   endgenerate

   always_comb begin
      unique case (kind)
         OPK_PROG: load_val = CW'(PROG_CYC - 1);
         OPK_SECT: load_val = CW'(SECT_CYC - 1);
         default:  load_val = CW'(CHIP_CYC - 1);
      endcase
   end

   assign accept = start && (phase == PH_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase <= PH_BUSY;
                  cnt   <= load_val;
               end
            end
            PH_BUSY: begin
               if (cnt == '0) begin
                  phase <= after_busy_ph;
                  cnt   <= after_busy_cnt;
               end else begin
                  cnt <= cnt - CW'(1);
               end
            end
            PH_SETTLE: begin
               if (cnt == '0) phase <= PH_IDLE;
               else           cnt   <= cnt - CW'(1);
            end
            default: begin
               phase <= PH_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   // R6: an accepted start enters the running phase on the next edge
   p_enter_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && start) |=> (phase == PH_BUSY));

   // R6: the running phase counts down one step per edge
   p_busy_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_BUSY && cnt != '0) |=> (phase == PH_BUSY && cnt == $past(cnt) - CW'(1)));

   // R11: a start during an operation does not reload the timer
   p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && start && cnt != '0) |=> (phase == $past(phase)));

endmodule

// File: rtl/fsg_toggle_bit.sv
module fsg_toggle_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_en,
   input  logic busy,
   output logic tog_now
);

   logic rd_q;
   logic tog_q;
   logic rd_rise;

   assign rd_rise = rd_en && !rd_q;
   assign tog_now = (busy && rd_rise) ? ~tog_q : tog_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= 1'b0;
         tog_q <= 1'b0;
      end else begin
         rd_q  <= rd_en;
         tog_q <= tog_now;
      end
   end

   // R12: the toggle state is frozen while no operation is running
   p_tog_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(tog_q));

   // R5: a read held high steps the toggle at most once
   p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_q) |=> $stable(tog_q));

endmodule

// File: rtl/fsg_read_mux.sv
module fsg_read_mux
   import flash_status_pkg::*;
#(
   parameter int          DW       = 16,
   parameter int          POLL_BIT = 7,
   parameter int          TOG_BIT  = 6,
   parameter logic [15:0] MFR_ID   = 16'h00BF,
   parameter logic [15:0] DEV_ID   = 16'h272F
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  phase_e        phase,
   input  logic          erase,
   input  logic          poll_src,
   input  logic          tog_now,
   input  logic          id_mode,
   input  logic          rd_a0,
   input  logic [DW-1:0] array_word,
   output logic [DW-1:0] rd_word
);

   initial begin
      assert (DW >= 16) else $error("DW must hold the identification words");
      assert (POLL_BIT != TOG_BIT) else $error("status bits must differ");
      assert (POLL_BIT < DW && TOG_BIT < DW) else $error("status bit outside word");
   end

   localparam logic [DW-1:0] STAT_MASK = (DW'(1) << POLL_BIT) | (DW'(1) << TOG_BIT);

   logic [DW-1:0] mfr_w;
   logic [DW-1:0] dev_w;
   logic [DW-1:0] status_w;
   logic [DW-1:0] next_w;
   logic          poll_val;

   generate
      if (DW > 16) begin : g_wide_id
         assign mfr_w = {{(DW-16){1'b0}}, MFR_ID};
         assign dev_w = {{(DW-16){1'b0}}, DEV_ID};
      end else begin : g_exact_id
         assign mfr_w = MFR_ID;
         assign dev_w = DEV_ID;
      end
   endgenerate

   always_comb begin
      if (phase == PH_BUSY) poll_val = erase ? 1'b0 : ~poll_src;
      else                  poll_val = erase ? 1'b1 : poll_src;
      status_w           = '0;
      status_w[POLL_BIT] = poll_val;
      status_w[TOG_BIT]  = tog_now;
   end

   always_comb begin
      if (!rd_en)                 next_w = '0;
      else if (phase != PH_IDLE)  next_w = status_w;
      else if (id_mode)           next_w = rd_a0 ? dev_w : mfr_w;
      else                        next_w = array_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_word <= '0;
      else        rd_word <= next_w;
   end

   // R2: no read access drives a zero word
   p_idle_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rd_word == '0));

   // R4: an erase reports a low polling bit while running
   p_erase_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && phase == PH_BUSY && erase) |=> !rd_word[POLL_BIT]);

   // R8: only the two status bits may be set during an operation
   p_status_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && phase != PH_IDLE) |=> ((rd_word & ~STAT_MASK) == '0));

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
   import flash_status_pkg::*;
#(
   parameter int          DW         = 16,
   parameter int          PROG_CYC   = 8,
   parameter int          SECT_CYC   = 64,
   parameter int          CHIP_CYC   = 256,
   parameter int          SETTLE_CYC = 2,
   parameter logic [15:0] MFR_ID     = 16'h00BF,
   parameter logic [15:0] DEV_ID     = 16'h272F
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_start,
   input  logic [1:0]    op_kind,
   input  logic          prog_bit_in,
   input  logic [DW-1:0] array_word,
   input  logic          rd_en,
   input  logic          rd_a0,
   input  logic          id_mode,
   output logic [DW-1:0] rd_word
);

   localparam int POLL_BIT = 7;
   localparam int TOG_BIT  = 6;

   phase_e   phase;
   logic     accept;
   op_kind_e kind_q;
   logic     pbit_q;
   logic     tog_now;
   logic     busy;

   assign busy = (phase == PH_BUSY);

   fsg_op_timer #(
      .PROG_CYC   (PROG_CYC),
      .SECT_CYC   (SECT_CYC),
      .CHIP_CYC   (CHIP_CYC),
      .SETTLE_CYC (SETTLE_CYC)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (op_start),
      .kind   (op_kind_e'(op_kind)),
      .accept (accept),
      .phase  (phase)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= OPK_PROG;
         pbit_q <= 1'b0;
      end else if (accept) begin
         kind_q <= op_kind_e'(op_kind);
         pbit_q <= prog_bit_in;
      end
   end

   fsg_toggle_bit u_toggle (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .busy    (busy),
      .tog_now (tog_now)
   );

   fsg_read_mux #(
      .DW       (DW),
      .POLL_BIT (POLL_BIT),
      .TOG_BIT  (TOG_BIT),
      .MFR_ID   (MFR_ID),
      .DEV_ID   (DEV_ID)
   ) u_mux (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (rd_en),
      .phase      (phase),
      .erase      (kind_is_erase(kind_q)),
      .poll_src   (pbit_q),
      .tog_now    (tog_now),
      .id_mode    (id_mode),
      .rd_a0      (rd_a0),
      .array_word (array_word),
      .rd_word    (rd_word)
   );

   // R11: kind and program bit stay locked for the whole operation
   p_kind_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) |=> ($stable(kind_q) && $stable(pbit_q)));

   // R3: a running program shows the inverse of the latched bit
   p_prog_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && busy && kind_q == OPK_PROG) |=> (rd_word[POLL_BIT] != pbit_q));

endmodule

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;

   localparam int T_PROG   = 6;
   localparam int T_SECT   = 20;
   localparam int T_CHIP   = 40;
   localparam int T_SETTLE = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_start = 1'b0;
   logic [1:0]  op_kind = 2'b00;
   logic        prog_bit_in = 1'b0;
   logic [15:0] array_word = 16'h0000;
   logic        rd_en = 1'b0;
   logic        rd_a0 = 1'b0;
   logic        id_mode = 1'b0;
   logic [15:0] rd_word;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   flash_status_gen #(
      .DW (16), .PROG_CYC (T_PROG), .SECT_CYC (T_SECT),
      .CHIP_CYC (T_CHIP), .SETTLE_CYC (T_SETTLE)
   ) dut (
      .clk (clk), .rst_n (rst_n), .op_start (op_start), .op_kind (op_kind),
      .prog_bit_in (prog_bit_in), .array_word (array_word), .rd_en (rd_en),
      .rd_a0 (rd_a0), .id_mode (id_mode), .rd_word (rd_word)
   );

   // bench model: 0 idle, 1 running, 2 settling
   int          m_ph = 0;
   int          m_left = 0;
   int          m_kind = 0;
   logic        m_pbit = 1'b0;
   logic        m_tog = 1'b0;
   logic        m_rdq = 1'b0;
   bit          m_late_start = 0;
   bit          m_just_done = 0;
   bit          pend = 0;
   logic [15:0] pend_exp;
   string       pend_tag;

   function automatic int len_of(input int k);
      if (k == 0) return T_PROG;
      if (k == 1) return T_SECT;
      return T_CHIP;
   endfunction

   function automatic logic [15:0] exp_word(input int ph, input int k, input logic pb,
                                            input logic tg, input logic id, input logic a0,
                                            input logic [15:0] arr);
      logic [15:0] w;
      w = 16'h0000;
      if (ph == 1) begin
         w[7] = (k == 0) ? ~pb : 1'b0;
         w[6] = tg;
      end else if (ph == 2) begin
         w[7] = (k == 0) ? pb : 1'b1;
         w[6] = tg;
      end else if (id) begin
         w = a0 ? 16'h272F : 16'h00BF;
      end else begin
         w = arr;
      end
      return w;
   endfunction

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: rd_word actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic st, input logic [1:0] k, input logic pb,
                      input logic [15:0] aw, input logic rd, input logic a0, input logic id);
      @(negedge clk);
      if (pend) check(rd_word, pend_exp, pend_tag);
      op_start = st; op_kind = k; prog_bit_in = pb;
      array_word = aw; rd_en = rd; rd_a0 = a0; id_mode = id;
      // expectation for the edge that follows
      if (m_ph == 1 && rd && !m_rdq) m_tog = ~m_tog;
      pend_exp = rd ? exp_word(m_ph, m_kind, m_pbit, m_tog, id, a0, aw) : 16'h0000;
      if (!rd)              pend_tag = "R2";
      else if (m_ph == 1)   pend_tag = (m_kind == 0) ? "R3,R5,R8" : "R4,R5,R8";
      else if (m_ph == 2)   pend_tag = "R7,R8,R12";
      else if (id)          pend_tag = "R10";
      else                  pend_tag = "R9";
      if (m_ph == 0 && m_just_done) pend_tag = {pend_tag, ",R6,R12"};
      if (m_ph != 0 && m_late_start) pend_tag = {pend_tag, ",R11"};
      pend = 1;
      m_rdq = rd;
      // phase model step
      if (m_ph == 0) begin
         if (st) begin
            m_ph = 1; m_left = len_of(int'(k)); m_kind = int'(k); m_pbit = pb;
            m_late_start = 0; m_just_done = 0;
         end
      end else begin
         if (st) m_late_start = 1;
         m_left--;
         if (m_left == 0) begin
            if (m_ph == 1 && T_SETTLE > 0) begin
               m_ph = 2; m_left = T_SETTLE;
            end else begin
               m_ph = 0; m_just_done = 1;
            end
         end
      end
   endtask

   task automatic idle_read(input int n, input logic [15:0] aw);
      for (int i = 0; i < n; i++) cyc(1'b0, 2'b00, 1'b0, aw, 1'b1, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (4) @(negedge clk);
      check(rd_word, 16'h0000, "R1 reset");
      rst_n = 1'b1;
      cyc(1'b0, 2'b00, 1'b0, 16'hAAAA, 1'b0, 1'b0, 1'b0);

      // normal reads, erased word, idle strobe, identification words
      cyc(1'b0, 2'b00, 1'b0, 16'h1234, 1'b1, 1'b0, 1'b0);
      cyc(1'b0, 2'b00, 1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b0);
      cyc(1'b0, 2'b00, 1'b0, 16'h5A5A, 1'b0, 1'b0, 1'b0);
      cyc(1'b0, 2'b00, 1'b0, 16'h5A5A, 1'b1, 1'b0, 1'b1);
      cyc(1'b0, 2'b00, 1'b0, 16'h5A5A, 1'b1, 1'b1, 1'b1);
      cyc(1'b0, 2'b00, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);

      // R1 R3 R5: program with bit 7 set, short reads then a long read
      cyc(1'b1, 2'b00, 1'b1, 16'h0F0F, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 6; i++) cyc(1'b0, 2'b00, 1'b0, 16'h0F0F, i[0] == 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 8; i++) cyc(1'b0, 2'b00, 1'b0, 16'h0F0F, 1'b1, 1'b0, 1'b0);
      idle_read(2, 16'hFFFF);

      // R3 R10: program with bit 7 clear while identification mode is selected
      cyc(1'b1, 2'b00, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1);
      for (int i = 0; i < 11; i++) cyc(1'b0, 2'b00, 1'b1, 16'h0000, 1'b1, i[0], 1'b1);

      // R4 R11: sector erase with late start pulses of another kind
      cyc(1'b1, 2'b01, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 26; i++)
         cyc(i == 3 || i == 19, 2'b10, 1'b1, 16'hC3C3, i[1] == 1'b0, 1'b0, 1'b0);

      // R4 R6: chip erase (alternate code) read in one long access
      cyc(1'b1, 2'b11, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 46; i++) cyc(1'b0, 2'b00, 1'b0, 16'h7E81, 1'b1, 1'b0, 1'b0);

      // constrained random traffic
      for (int i = 0; i < 3000; i++) begin
         cyc(($urandom % 25) == 0, 2'($urandom), 1'($urandom), 16'($urandom),
             ($urandom % 3) != 0, 1'($urandom), ($urandom % 5) == 0);
      end
      cyc(1'b0, 2'b00, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule